// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Enable Unit

This unit collects interrupt sources from a byte-oriented SPI controller into one sticky status register and drives a single level-sensitive interrupt line. Event inputs are one-cycle pulses from the transfer engine: a completed byte exchange, transmit empty, transmit underrun, receive overrun and transmit half empty. Two level inputs carry the live receive FIFO state (not empty, full). The level inputs are ORed into the status register on every cycle, so those bits cannot stay cleared while their condition persists.

Software reaches three word registers on a simple register bus: a global enable, the status register and a per-source enable register. A write to the status register XORs the written value into it, so writing a 1 flips that bit. The interrupt line is high when the global enable is on and at least one status bit has its enable set. A hardware reset or a soft-reset pulse from the controller clears all three registers.

Top module: `spi_irq_unit`

## Requirements
- R1: After hardware reset the global enable, status and per-source enable registers read 0, and irq is 0.
- R2: Byte offset 0x1C holds the global enable in bit 31, 0x20 holds status and 0x28 holds the per-source enable. A read returns on bus_rdata one cycle after bus_re, showing register contents from before that edge. Any other offset reads 0.
- R3: A one-cycle pulse sets a status bit that stays set after the pulse ends: ev_tx_empty sets bit 2, ev_tx_underrun bit 3, ev_rx_overrun bit 5, ev_tx_half_empty bit 6.
- R4: A pulse on ev_xfer_done sets status bits 2 and 8 together.
- R5: While rx_full is high, status bit 4 is set again on every cycle, and while rx_not_empty is high, bit 8 is. A write that toggles either bit cannot clear it while its level is high.
- R6: A status write XORs the write data into the register: a written 1 clears a set bit and sets a clear bit, and a written 0 leaves the bit unchanged.
- R7: When an event and a status-write toggle hit the same bit in the same cycle, the bit ends up set.
- R8: irq is registered. It equals global enable AND (status AND per-source enable is non-zero), taken from the register values written at the same clock edge.
- R9: A soft_rst pulse clears the global enable, status and per-source enable registers, and irq becomes 0 at the same edge.
- R10: Status and per-source enable bits 0, 1, 7 and 9 to 31 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft-reset pulse from the controller |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_re |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_tx_underrun | input | 1 | Transmit underrun event pulse |
| ev_rx_overrun | input | 1 | Receive overrun event pulse |
| ev_tx_half_empty | input | 1 | Transmit half-empty event pulse |
| ev_xfer_done | input | 1 | Byte exchanged event pulse |
| rx_not_empty | input | 1 | Live receive FIFO not-empty level |
| rx_full | input | 1 | Live receive FIFO full level |
| irq | output | 1 | Level interrupt output |

## Verification
A status bit that is lost, or one that is set when it should not be, shows at the ports in two ways. It changes irq at the next edge whenever that bit is enabled and the global enable is on. It also shows in the next status read, one cycle after the read strobe. The bench therefore compares irq against a reference model on every cycle and compares every read against the model's register values. A wrong XOR, a wrong priority between an event and a toggle, or a missed level re-assert is seen within one cycle when enabled, and otherwise at the next read.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int SRC_W = 9;

  localparam int B_TXE  = 2;
  localparam int B_TXU  = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXO  = 5;
  localparam int B_TXH  = 6;
  localparam int B_RXNE = 8;

  localparam logic [SRC_W-1:0] SRC_MASK = SRC_W'((1 << B_TXE) | (1 << B_TXU) | (1 << B_RXF) |
                                                 (1 << B_RXO) | (1 << B_TXH) | (1 << B_RXNE));

  localparam int OFF_GIE  = 'h1C;
  localparam int OFF_STAT = 'h20;
  localparam int OFF_EN   = 'h28;
endpackage

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              gie_q,
  input  logic [SRC_W-1:0]  st_q,
  input  logic [SRC_W-1:0]  en_q,
  output logic              wr_gie,
  output logic              wr_stat,
  output logic              wr_en,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - SRC_W;

  logic hit_gie, hit_stat, hit_en;

  assign hit_gie  = (bus_addr == ADDR_W'(OFF_GIE));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_en   = (bus_addr == ADDR_W'(OFF_EN));

  assign wr_gie  = bus_we & hit_gie;
  assign wr_stat = bus_we & hit_stat;
  assign wr_en   = bus_we & hit_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_re) begin
      if (hit_gie)       rdata <= {gie_q, {(DATA_W-1){1'b0}}};
      else if (hit_stat) rdata <= {{PAD_W{1'b0}}, st_q};
      else if (hit_en)   rdata <= {{PAD_W{1'b0}}, en_q};
      else               rdata <= '0;
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             wr_gie,
  input  logic             wr_stat,
  input  logic             wr_en,
  input  logic             wd_gie,
  input  logic [SRC_W-1:0] wd_src,
  input  logic             ev_tx_empty,
  input  logic             ev_tx_underrun,
  input  logic             ev_rx_overrun,
  input  logic             ev_tx_half_empty,
  input  logic             ev_xfer_done,
  input  logic             rx_not_empty,
  input  logic             rx_full,
  output logic             gie_q,
  output logic [SRC_W-1:0] st_q,
  output logic [SRC_W-1:0] en_q,
  output logic             gie_n,
  output logic [SRC_W-1:0] st_n,
  output logic [SRC_W-1:0] en_n
);
  logic             clr;
  logic [SRC_W-1:0] set_vec;

  assign clr = rst | soft_rst;

  always_comb begin
    set_vec         = '0;
    set_vec[B_TXE]  = ev_tx_empty | ev_xfer_done;
    set_vec[B_TXU]  = ev_tx_underrun;
    set_vec[B_RXF]  = rx_full;
    set_vec[B_RXO]  = ev_rx_overrun;
    set_vec[B_TXH]  = ev_tx_half_empty;
    set_vec[B_RXNE] = ev_xfer_done | rx_not_empty;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_live
      assign st_n[i] = ~clr & ((st_q[i] ^ (wr_stat & wd_src[i])) | set_vec[i]);
      assign en_n[i] = ~clr & (wr_en ? wd_src[i] : en_q[i]);
    end else begin : g_tied
      assign st_n[i] = 1'b0;
      assign en_n[i] = 1'b0;
    end
  end

  assign gie_n = ~clr & (wr_gie ? wd_gie : gie_q);

  always_ff @(posedge clk) begin
    st_q  <= st_n;
    en_q  <= en_n;
    gie_q <= gie_n;
  end
endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             gie_n,
  input  logic [SRC_W-1:0] st_n,
  input  logic [SRC_W-1:0] en_n,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie_n & (|(st_n & en_n));
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half_empty,
  input  logic              ev_xfer_done,
  input  logic              rx_not_empty,
  input  logic              rx_full,
  output logic              irq
);
  logic             wr_gie, wr_stat, wr_en;
  logic             gie_q, gie_n;
  logic [SRC_W-1:0] st_q, st_n, en_q, en_n;

  spi_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .bus_we  (bus_we),
    .bus_re  (bus_re),
    .bus_addr(bus_addr),
    .gie_q   (gie_q),
    .st_q    (st_q),
    .en_q    (en_q),
    .wr_gie  (wr_gie),
    .wr_stat (wr_stat),
    .wr_en   (wr_en),
    .rdata   (bus_rdata)
  );

  spi_irq_status u_status (
    .clk             (clk),
    .rst             (rst),
    .soft_rst        (soft_rst),
    .wr_gie          (wr_gie),
    .wr_stat         (wr_stat),
    .wr_en           (wr_en),
    .wd_gie          (bus_wdata[DATA_W-1]),
    .wd_src          (bus_wdata[SRC_W-1:0]),
    .ev_tx_empty     (ev_tx_empty),
    .ev_tx_underrun  (ev_tx_underrun),
    .ev_rx_overrun   (ev_rx_overrun),
    .ev_tx_half_empty(ev_tx_half_empty),
    .ev_xfer_done    (ev_xfer_done),
    .rx_not_empty    (rx_not_empty),
    .rx_full         (rx_full),
    .gie_q           (gie_q),
    .st_q            (st_q),
    .en_q            (en_q),
    .gie_n           (gie_n),
    .st_n            (st_n),
    .en_n            (en_n)
  );

  spi_irq_line u_line (
    .clk  (clk),
    .rst  (rst),
    .gie_n(gie_n),
    .st_n (st_n),
    .en_n (en_n),
    .irq  (irq)
  );
endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ev_tx_underrun,
  input logic              rx_full,
  input logic              gie_q,
  input logic [SRC_W-1:0]  st_q,
  input logic [SRC_W-1:0]  en_q,
  input logic              irq
);
  logic stat_wr;
  assign stat_wr = bus_we & (bus_addr == ADDR_W'(OFF_STAT));

  // R3: without a status write or soft reset, no set bit falls
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && !stat_wr) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R7: an underrun event sets bit 3 even under a toggle
  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_underrun && !soft_rst) |=> st_q[B_TXU]);

  // R5: full level re-asserts bit 4
  p_level_full_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !soft_rst) |=> st_q[B_RXF]);

  // R9: soft reset clears everything
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (st_q == '0 && en_q == '0 && !gie_q && !irq));

  // R8: irq only with global enable and an enabled pending source
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gie_q && (|(st_q & en_q))));

  // R10: unimplemented bits stay zero
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~SRC_MASK) == '0) && ((en_q & ~SRC_MASK) == '0));
endmodule

bind spi_irq_unit spi_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .soft_rst      (soft_rst),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .ev_tx_underrun(ev_tx_underrun),
  .rx_full       (rx_full),
  .gie_q         (gie_q),
  .st_q          (st_q),
  .en_q          (en_q),
  .irq           (irq)
);

// File: tb/spi_irq_unit_test.sv
`timescale 1ns/1ps
module spi_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_tx_empty = 0, ev_tx_underrun = 0, ev_rx_overrun = 0;
  logic        ev_tx_half_empty = 0, ev_xfer_done = 0;
  logic        rx_not_empty = 0, rx_full = 0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic        m_gie = 0;
  logic [8:0]  m_st = '0, m_en = '0;
  localparam logic [8:0] MASK = 9'h17C;

  always #2.5 clk = ~clk;

  spi_irq_unit uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gie, 31'b0};
      8'h20:   return {23'b0, m_st};
      8'h28:   return {23'b0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [8:0] set_bits();
    logic [8:0] s = '0;
    s[2] = ev_tx_empty | ev_xfer_done;
    s[3] = ev_tx_underrun;
    s[4] = rx_full;
    s[5] = ev_rx_overrun;
    s[6] = ev_tx_half_empty;
    s[8] = ev_xfer_done | rx_not_empty;
    return s;
  endfunction

  task automatic tick();
    logic [31:0] exp_rd;
    logic        did_rd;
    did_rd = bus_re;
    exp_rd = model_read(bus_addr);
    if (rst || soft_rst) begin
      m_gie = 0; m_st = '0; m_en = '0;
    end else begin
      if (bus_we && bus_addr == 8'h1C) m_gie = bus_wdata[31];
      if (bus_we && bus_addr == 8'h28) m_en = bus_wdata[8:0] & MASK;
      m_st = ((m_st ^ ((bus_we && bus_addr == 8'h20) ? bus_wdata[8:0] : 9'h0)) | set_bits()) & MASK;
    end
    if (rst) exp_rd = '0;
    @(posedge clk); #1;
    check("R8 irq", {31'b0, irq}, {31'b0, (m_gie && |(m_st & m_en))});
    if (did_rd) check("R2 read", bus_rdata, exp_rd);
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; soft_rst = 0;
    ev_tx_empty = 0; ev_tx_underrun = 0; ev_rx_overrun = 0;
    ev_tx_half_empty = 0; ev_xfer_done = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; tick(); idle();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_re = 1; bus_addr = a; tick(); idle();
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; tick(); tick(); rst = 0;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h20, 32'h0, "R1 status zero");
    rd(8'h28, 32'h0, "R1 enable zero");
    rd(8'h1C, 32'h0, "R1 global zero");
    rd(8'h24, 32'h0, "R2 unmapped reads zero");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0000_017C, "R10 enable undefined bits");
    ev_tx_underrun = 1; tick(); idle(); tick();
    rd(8'h20, 32'h0000_0008, "R3 underrun sticky");
    wr(8'h1C, 32'h8000_0000);
    check("R8 irq rises", {31'b0, irq}, 32'h1);
    rd(8'h1C, 32'h8000_0000, "R2 global bit31");
    wr(8'h20, 32'h0000_0008);
    check("R6 toggle clears, irq low", {31'b0, irq}, 32'h0);
    wr(8'h20, 32'h0000_0040);
    rd(8'h20, 32'h0000_0040, "R6 toggle sets");
    ev_tx_half_empty = 1; bus_we = 1; bus_addr = 8'h20; bus_wdata = 32'h40; tick(); idle();
    rd(8'h20, 32'h0000_0040, "R7 event beats toggle");
    ev_xfer_done = 1; tick(); idle();
    rd(8'h20, 32'h0000_0144, "R4 transfer sets 2 and 8");
    ev_tx_empty = 1; ev_rx_overrun = 1; tick(); idle();
    rd(8'h20, 32'h0000_0164, "R3 empty and overrun");
    rx_full = 1; tick();
    wr(8'h20, 32'h0000_0010);
    rd(8'h20, 32'h0000_0174, "R5 level re-asserts");
    rx_full = 0; wr(8'h20, 32'h0000_0010);
    rd(8'h20, 32'h0000_0164, "R5 clears once level low");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0000_0018, "R10 status undefined bits");
    soft_rst = 1; tick(); idle();
    check("R9 irq after soft reset", {31'b0, irq}, 32'h0);
    rd(8'h20, 32'h0, "R9 status cleared");
    rd(8'h28, 32'h0, "R9 enable cleared");
    rd(8'h1C, 32'h0, "R9 global cleared");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 4));
      bus_addr = (sel == 0) ? 8'h1C : (sel == 1) ? 8'h20 : (sel == 2) ? 8'h28 :
                 (sel == 3) ? 8'h24 : 8'h40;
      bus_we = ($urandom_range(0, 3) == 0);
      bus_re = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom();
      ev_tx_empty = ($urandom_range(0, 7) == 0);
      ev_tx_underrun = ($urandom_range(0, 7) == 0);
      ev_rx_overrun = ($urandom_range(0, 7) == 0);
      ev_tx_half_empty = ($urandom_range(0, 7) == 0);
      ev_xfer_done = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) rx_full = ~rx_full;
      if ($urandom_range(0, 15) == 0) rx_not_empty = ~rx_not_empty;
      soft_rst = ($urandom_range(0, 199) == 0);
      tick();
    end
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule